// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block is a memory-mapped timer peripheral with a configurable number of independent 32-bit down-counting channels. Each channel holds a reload constant, a live counter and a 16-bit control register. The control register selects a count-clock divider from one shared free-running prescaler, enables the channel's interrupt, and holds a sticky underflow flag. One shared start register gates every channel, one bit per channel. Software starts or stops a single channel with a read-modify-write of that register.

While a channel runs, its counter decrements once per selected prescaler tick. When a tick arrives with the counter at zero, the counter reloads from the constant and the flag is set. A constant equal to the period therefore gives periodic events. With a constant of all ones, the inverted counter gives the ticks elapsed since it was loaded, which suits a free-running time base. The channel's interrupt line is the flag gated by the enable. Software acknowledges an event by writing the control register with the flag bit at zero.

The register bus is a simple synchronous request port with an address, a write strobe and an access size. The bus interface is a two-state machine. In `BUS_IDLE` no read response is due. An accepted read moves it to `BUS_RESP` for one cycle, and in that cycle the response is presented. From `BUS_RESP` it returns to `BUS_IDLE`, unless another read arrives in that cycle, in which case it stays in `BUS_RESP`.

Top module: `multi_timer`

## Requirements
- R1: After reset every reload constant and counter reads 0xFFFFFFFF, every control register reads 0x0000, the start register reads 0x00, and every interrupt output is low.
- R2: The start register is at byte address 0x00. Channel n has its reload constant at 0x04+12n, its counter at 0x08+12n and its control register at 0x0C+12n. A read accepted at a clock edge drives rd_valid high and presents the data for exactly the following cycle.
- R3: Access sizes are encoded as 0 = byte, 1 = half-word and 2 = word. The start register takes byte accesses, a control register takes half-word accesses, and constants and counters take word accesses. A write with the wrong size, to a misaligned address or to an unmapped address changes nothing. A read of that kind returns zero.
- R4: Start bit n runs channel n. While the bit is clear the counter holds its value. Start bits at positions NUM_CH and above cannot be set and read as zero.
- R5: Control bits [2:0] select the count clock. Code 0 divides by 4, 1 by 16, 2 by 64, 3 by 256 and 4 by 1024. Codes 5 to 7 hold the count. A tick for divider D occurs in every cycle where the number of cycles since reset release, taken modulo D, equals D-1.
- R6: On each tick of a running channel the counter decrements by one. If the counter is zero at that tick, it instead reloads from the constant and the flag (control bit 8) is set.
- R7: Each channel's irq bit equals the flag ANDed with the interrupt enable (control bit 5). Control bits other than 8, 5 and 2:0 read as zero.
- R8: A control write with bit 8 at zero clears the flag. A write with bit 8 at one leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: A bus write to a counter takes priority over a decrement or reload in the same cycle.
- R10: When a counter is loaded with all ones, its bitwise inverse equals the number of ticks elapsed since the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data, right-aligned |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
A write takes effect at the edge that samples it. Read data and rd_valid appear one cycle after the read is sampled, so the bench checks them at the next falling edge. A counter step, a reload and the matching flag change happen at the edge that carries the prescaler tick, and irq follows at that same edge, so it is checked at the falling edge after it. A behavioural model in the bench steps at every rising edge from the same inputs and counts prescaler phases from reset release. At every falling edge, the model's irq value and read response are compared with the outputs. Directed reads add fixed expected values for the reset state, ignored accesses, held counters and control readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W     = 32;
    localparam int CTRL_W     = 16;
    localparam int PSC_W      = 3;
    localparam int NUM_DIV    = 5;
    localparam int DIV_BASE   = 2;
    localparam int DIV_STEP   = 2;
    localparam int FLAG_BIT   = 8;
    localparam int IE_BIT     = 5;
    localparam int REGS_PER_CH = 3;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        RG_CONST = 2'd0,
        RG_COUNT = 2'd1,
        RG_CTRL  = 2'd2
    } ch_reg_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int N_DIV = NUM_DIV,
    parameter int BASE  = DIV_BASE,
    parameter int STEP  = DIV_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [N_DIV-1:0] tick
);
    localparam int PW = BASE + STEP * (N_DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < N_DIV; k++) begin : g_tap
            assign tick[k] = &phase_q[BASE+STEP*k-1:0];
        end
    endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int N_DIV = NUM_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [N_DIV-1:0]  tick,
    input  logic              wr_const,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] const_q,
    output logic [DATA_W-1:0] count_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              irq
);
    logic [PSC_W-1:0] psc_q;
    logic             ie_q;
    logic             flag_q;
    logic             sel_tick;
    logic             step;
    logic             underflow;

    always_comb begin
        sel_tick = 1'b0;
        for (int k = 0; k < N_DIV; k++) begin
            if (psc_q == PSC_W'(k)) begin
                sel_tick = tick[k];
            end
        end
    end

    assign step      = run && sel_tick;
    assign underflow = step && !wr_count && (count_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            const_q <= '1;
            count_q <= '1;
            psc_q   <= '0;
            ie_q    <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_const) begin
                const_q <= wdata;
            end
            if (wr_count) begin
                count_q <= wdata;
            end else if (step) begin
                if (count_q == '0) begin
                    count_q <= const_q;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            if (wr_ctrl) begin
                psc_q <= wdata[PSC_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end
            if (underflow) begin
                flag_q <= 1'b1;
            end else if (wr_ctrl && !wdata[FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_q           = '0;
        ctrl_q[PSC_W-1:0] = psc_q;
        ctrl_q[IE_BIT]   = ie_q;
        ctrl_q[FLAG_BIT] = flag_q;
    end

    assign irq = flag_q && ie_q;
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
    import tmr_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_size,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [N_CH-1:0][DATA_W-1:0]  ch_const,
    input  logic [N_CH-1:0][DATA_W-1:0]  ch_count,
    input  logic [N_CH-1:0][CTRL_W-1:0]  ch_ctrl,
    output logic [N_CH-1:0]              start_q,
    output logic [N_CH-1:0]              wr_const,
    output logic [N_CH-1:0]              wr_count,
    output logic [N_CH-1:0]              wr_ctrl,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int WI_W = ADDR_W - 2;

    bus_state_e         state_q;
    bus_state_e         state_d;
    logic [WI_W-1:0]    word;
    logic               aligned;
    logic               rd_req;
    logic               wr_req;
    logic               hit_start;
    logic [N_CH-1:0]    hit_const;
    logic [N_CH-1:0]    hit_count;
    logic [N_CH-1:0]    hit_ctrl;
    logic [DATA_W-1:0]  rd_mux;

    assign word    = req_addr[ADDR_W-1:2];
    assign aligned = (req_addr[1:0] == 2'b00);
    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;

    always_comb begin
        hit_start = aligned && (word == '0) && (req_size == SZ_BYTE);
        for (int c = 0; c < N_CH; c++) begin
            hit_const[c] = aligned && (req_size == SZ_WORD) &&
                (word == WI_W'(1 + REGS_PER_CH * c + int'(RG_CONST)));
            hit_count[c] = aligned && (req_size == SZ_WORD) &&
                (word == WI_W'(1 + REGS_PER_CH * c + int'(RG_COUNT)));
            hit_ctrl[c]  = aligned && (req_size == SZ_HALF) &&
                (word == WI_W'(1 + REGS_PER_CH * c + int'(RG_CTRL)));
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_start) begin
            rd_mux = DATA_W'(start_q);
        end
        for (int c = 0; c < N_CH; c++) begin
            if (hit_const[c]) begin
                rd_mux = ch_const[c];
            end
            if (hit_count[c]) begin
                rd_mux = ch_count[c];
            end
            if (hit_ctrl[c]) begin
                rd_mux = DATA_W'(ch_ctrl[c]);
            end
        end
    end

    assign wr_const = hit_const & {N_CH{wr_req}};
    assign wr_count = hit_count & {N_CH{wr_req}};
    assign wr_ctrl  = hit_ctrl  & {N_CH{wr_req}};

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            start_q <= '0;
        end else begin
            if (rd_req) begin
                rd_data <= rd_mux;
            end
            if (wr_req && hit_start) begin
                start_q <= req_wdata[N_CH-1:0];
            end
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_RESP: rd_valid = 1'b1;
            default:  rd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq
);
    localparam int WORDS_USED = 1 + REGS_PER_CH * NUM_CH;

    initial begin
        if (NUM_CH < 1 || NUM_CH > 8 || WORDS_USED > (1 << (ADDR_W - 2))) begin
            $error("multi_timer: NUM_CH or ADDR_W out of range");
        end
    end

    logic [NUM_DIV-1:0]             tick;
    logic [NUM_CH-1:0]              start_q;
    logic [NUM_CH-1:0]              wr_const;
    logic [NUM_CH-1:0]              wr_count;
    logic [NUM_CH-1:0]              wr_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_const;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_count;
    logic [NUM_CH-1:0][CTRL_W-1:0]  ch_ctrl;

    tmr_prescaler #(
        .N_DIV(NUM_DIV),
        .BASE (DIV_BASE),
        .STEP (DIV_STEP)
    ) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tmr_regbus #(
        .N_CH  (NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_wdata(req_wdata),
        .ch_const (ch_const),
        .ch_count (ch_count),
        .ch_ctrl  (ch_ctrl),
        .start_q  (start_q),
        .wr_const (wr_const),
        .wr_count (wr_count),
        .wr_ctrl  (wr_ctrl),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            tmr_channel #(
                .N_DIV(NUM_DIV)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (start_q[c]),
                .tick    (tick),
                .wr_const(wr_const[c]),
                .wr_count(wr_count[c]),
                .wr_ctrl (wr_ctrl[c]),
                .wdata   (req_wdata),
                .const_q (ch_const[c]),
                .count_q (ch_count[c]),
                .ctrl_q  (ch_ctrl[c]),
                .irq     (irq[c])
            );
        end
    endgenerate
endmodule

// File: rtl/multi_timer_chk.sv
module multi_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [NUM_CH-1:0] irq
);
    // R2: an accepted read is answered in the next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R2: no response without a read in the previous cycle
    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R3: a misaligned read returns zero
    a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr[1:0] != 2'b00)) |=> (rd_data == 32'd0));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
            // R8: an interrupt only drops after a bus write
            a_r8_irq_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq[c]) |-> $past(req_valid && req_write));
        end
    endgenerate
endmodule

bind multi_timer multi_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_multi_timer.sv
`timescale 1ns/1ps
module tb_multi_timer;
    localparam int NCH = 3;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [NCH-1:0] irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    multi_timer #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_const [NCH];
    logic [31:0] m_cnt   [NCH];
    int          m_psc   [NCH];
    bit          m_ie    [NCH];
    bit          m_flag  [NCH];
    logic [7:0]  m_start;
    int          m_pre;
    logic [31:0] m_rdata;
    bit          m_rvalid;
    bit          m_live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_const[c] = 32'hFFFF_FFFF; m_cnt[c] = 32'hFFFF_FFFF;
                m_psc[c] = 0; m_ie[c] = 0; m_flag[c] = 0;
            end
            m_start = 0; m_pre = 0; m_rvalid = 0; m_rdata = 0;
        end else begin
            int w; int ch; int rg; bit ok_acc; bit rd; bit wr;
            logic [31:0] rv;
            int sz;
            sz = int'(req_size);
            rd = req_valid && !req_write;
            wr = req_valid && req_write;
            w = int'(req_addr) / 4;
            ch = -1; rg = -1; ok_acc = 0;
            if (int'(req_addr) % 4 == 0) begin
                if (w == 0) ok_acc = (sz == 0);
                else if (w <= 3 * NCH) begin
                    ch = (w - 1) / 3; rg = (w - 1) % 3;
                    ok_acc = (rg == 2) ? (sz == 1) : (sz == 2);
                end
            end
            rv = 0;
            if (ok_acc) begin
                if (w == 0) rv = {24'd0, m_start};
                else if (rg == 0) rv = m_const[ch];
                else if (rg == 1) rv = m_cnt[ch];
                else rv = {23'd0, m_flag[ch], 2'd0, m_ie[ch], 2'd0, 3'(m_psc[ch])};
            end
            for (int c = 0; c < NCH; c++) begin
                bit t; bit uf; bit wc; int d;
                d = (m_psc[c] < 5) ? (4 << (2 * m_psc[c])) : 0;
                t = m_start[c] && (d != 0) && ((m_pre % (d == 0 ? 1 : d)) == d - 1);
                wc = wr && ok_acc && ch == c && rg == 1;
                uf = 0;
                if (wc) m_cnt[c] = req_wdata;
                else if (t) begin
                    if (m_cnt[c] == 0) begin m_cnt[c] = m_const[c]; uf = 1; end
                    else m_cnt[c] = m_cnt[c] - 1;
                end
                if (wr && ok_acc && ch == c && rg == 2) begin
                    m_psc[c] = int'(req_wdata[2:0]);
                    m_ie[c] = req_wdata[5];
                    if (!req_wdata[8] && !uf) m_flag[c] = 0;
                end
                if (uf) m_flag[c] = 1;
                if (wr && ok_acc && ch == c && rg == 0) m_const[c] = req_wdata;
            end
            if (wr && ok_acc && w == 0) m_start = {5'd0, req_wdata[2:0]};
            m_pre++;
            m_rvalid = rd;
            if (rd) m_rdata = rv;
            m_live = 1'b1;
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (m_live && rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                chk(irq[c] == (m_flag[c] && m_ie[c]), "R7 irq vs model",
                    32'(irq[c]), 32'(m_flag[c] && m_ie[c]));
            end
            chk(rd_valid == m_rvalid, "R2 rd_valid vs model", 32'(rd_valid), 32'(m_rvalid));
            if (m_rvalid) chk(rd_data == m_rdata, "R6 rd_data vs model", rd_data, m_rdata);
        end
    end

    task automatic bus_wr(input int a, input int sz, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_size = 2'(sz); req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input int a, input int sz, output logic [31:0] v);
        req_valid = 1; req_write = 0; req_addr = AW'(a); req_size = 2'(sz);
        @(negedge clk);
        req_valid = 0;
        v = rd_data;
    endtask

    task automatic rd_chk(input int a, input int sz, input logic [31:0] e, input string tag);
        logic [31:0] v;
        bus_rd(a, sz, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic wait_irq(input int c, input int lim, input string tag);
        bit seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (irq[c]) seen = 1;
        end
        chk(seen, tag, 32'(seen), 32'd1);
    endtask

    function automatic int a_const(int c); return 4 + 12 * c; endfunction
    function automatic int a_cnt(int c);   return 8 + 12 * c; endfunction
    function automatic int a_ctrl(int c);  return 12 + 12 * c; endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq == '0, "R1 irq after reset", 32'(irq), 0);
        rd_chk(0, 0, 32'h0, "R1 start reset");
        for (int c = 0; c < NCH; c++) begin
            rd_chk(a_const(c), 2, 32'hFFFF_FFFF, "R1 const reset");
            rd_chk(a_cnt(c), 2, 32'hFFFF_FFFF, "R1 count reset");
            rd_chk(a_ctrl(c), 1, 32'h0, "R1 ctrl reset");
        end
        // R3 size and alignment
        rd_chk(a_const(0), 1, 32'h0, "R3 wrong-size read");
        bus_wr(a_cnt(0), 0, 32'h12);
        rd_chk(a_cnt(0), 2, 32'hFFFF_FFFF, "R3 wrong-size write ignored");
        bus_wr(a_cnt(0) + 1, 2, 32'h34);
        rd_chk(a_cnt(0), 2, 32'hFFFF_FFFF, "R3 misaligned write ignored");
        rd_chk(a_cnt(0) + 2, 2, 32'h0, "R3 misaligned read zero");
        rd_chk(4 + 12 * NCH, 2, 32'h0, "R3 unmapped read zero");
        // R10 free-running elapsed count
        bus_wr(0, 0, 32'h1);
        repeat (40) @(negedge clk);
        bus_wr(0, 0, 32'h0);
        bus_rd(a_cnt(0), 2, v1);
        chk((~v1) >= 32'd8 && (~v1) <= 32'd11, "R10 inverted count", ~v1, 32'd10);
        // R4 stopped counter holds
        repeat (20) @(negedge clk);
        bus_rd(a_cnt(0), 2, v2);
        chk(v1 == v2, "R4 stopped count holds", v2, v1);
        // R6 reload and flag
        bus_wr(a_const(0), 2, 32'd3);
        bus_wr(a_cnt(0), 2, 32'd3);
        bus_wr(a_ctrl(0), 1, 32'h0020);
        bus_wr(0, 0, 32'h1);
        wait_irq(0, 100, "R6 underflow raises irq");
        bus_wr(0, 0, 32'h0);
        rd_chk(a_ctrl(0), 1, 32'h0120, "R6 flag set in ctrl");
        // R8 acknowledge
        bus_wr(a_ctrl(0), 1, 32'h0120);
        chk(irq[0] == 1'b1, "R8 writing flag one keeps it", 32'(irq[0]), 1);
        bus_wr(a_ctrl(0), 1, 32'h0020);
        chk(irq[0] == 1'b0, "R8 writing flag zero clears", 32'(irq[0]), 0);
        // R5 prescaler codes, several channels
        bus_wr(a_const(1), 2, 32'd2);
        bus_wr(a_cnt(1), 2, 32'd2);
        bus_wr(a_ctrl(1), 1, 32'h0021);
        bus_wr(a_cnt(2), 2, 32'h1234);
        bus_wr(a_ctrl(2), 1, 32'h0025);
        bus_wr(0, 0, 32'h7);
        wait_irq(1, 200, "R5 divide-by-16 channel underflows");
        repeat (300) @(negedge clk);
        rd_chk(a_cnt(2), 2, 32'h1234, "R5 hold code keeps count");
        rd_chk(0, 0, 32'h7, "R4 start readback");
        bus_wr(0, 0, 32'hFF);
        rd_chk(0, 0, 32'h7, "R4 upper start bits read zero");
        // R9 back-to-back counter writes while running
        for (int i = 0; i < 8; i++) bus_wr(a_cnt(0), 2, 32'h100 + i);
        rd_chk(a_cnt(0), 2, 32'h107, "R9 write overrides decrement");
        // R5 divide-by-1024
        bus_wr(a_const(2), 2, 32'd1);
        bus_wr(a_cnt(2), 2, 32'd1);
        bus_wr(a_ctrl(2), 1, 32'h0024);
        wait_irq(2, 2200, "R5 divide-by-1024 underflow");
        repeat (50) @(negedge clk);
        // R7 control readback of unused bits
        bus_wr(0, 0, 32'h0);
        bus_wr(a_ctrl(0), 1, 32'hFEFF);
        rd_chk(a_ctrl(0), 1, 32'h0027, "R7 ctrl unused bits zero");
        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule